// File: doc/BRIEF.md
# APB Read Manager with Wait Tracking

This block is the manager side of an APB link, restricted to single read transfers. A local agent asks for a read by raising a request strobe together with an address. The block then drives the bus through its idle, setup and access phases. It keeps the access frozen for however many wait cycles the subordinate inserts, and returns the read data and the error bit with a one-cycle done pulse. The write-direction output is tied low.

Read data and the error response are taken from the bus only on the completion cycle, which is the cycle in which select, enable and ready are all high. Whatever the subordinate drives on those lines during wait cycles has no effect. A long stall counts as normal backpressure. An optional wait counter raises a separate watchdog flag once a configurable number of wait cycles has passed, and it leaves the transfer running.

Top module: `apb_rd_mgr`

## Requirements
- R1: After a request is accepted, the next cycle is a single setup cycle: `psel_o`=1, `penable_o`=0, `paddr_o` equal to the requested address and `pwrite_o`=0. The cycle after that is an access cycle. `pwrite_o` is 0 in every cycle.
- R2: In every access cycle up to and including completion, `psel_o` and `penable_o` are both 1. A stalled transfer never goes back to setup.
- R3: `paddr_o` and `pwrite_o` do not change between a wait cycle (`penable_o`=1, `pready_i`=0) and the cycle that follows it.
- R4: The transfer completes in the first access cycle with `pready_i`=1. A transfer with N wait cycles has exactly N+1 access cycles, for any N.
- R5: `done_o` is high for exactly one cycle, the cycle after completion. In that cycle `rdata_o` holds the `prdata_i` value from the completion cycle. Values on `prdata_i` in wait cycles have no effect, and `rdata_o` keeps its value until the next `done_o`.
- R6: `err_o` is the `pslverr_i` value from the completion cycle. `pslverr_i` in wait cycles is ignored, and no number of waits sets `err_o`.
- R7: After completion the bus goes idle (`psel_o`=0) in the next cycle. The exception is when `req_i` is high during the completion cycle: then the next cycle is directly the setup cycle of a new transfer to the new address.
- R8: `req_i` raised during setup or during a wait cycle is ignored. It starts no transfer and does not change `paddr_o`.
- R9: With the watchdog enabled, `wdog_o` is 1 from the cycle after the WDOG_LIMIT-th wait cycle of a transfer up to and including its completion cycle, and 0 at all other times. The transfer still completes normally.
- R10: During and right after reset, `psel_o`, `penable_o`, `done_o`, `wdog_o` and `busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request strobe |
| req_addr_i | input | ADDR_W | Address of the requested read |
| busy_o | output | 1 | A transfer is in setup or access |
| done_o | output | 1 | One-cycle pulse: read result is valid |
| rdata_o | output | DATA_W | Captured read data |
| err_o | output | 1 | Captured error response |
| wdog_o | output | 1 | Wait count has reached WDOG_LIMIT |
| psel_o | output | 1 | APB select |
| penable_o | output | 1 | APB enable |
| pwrite_o | output | 1 | APB direction, always 0 |
| paddr_o | output | ADDR_W | APB address |
| prdata_i | input | DATA_W | APB read data |
| pready_i | input | 1 | APB ready |
| pslverr_i | input | 1 | APB error response |

## Verification
The embedded assertions check the bus shape on every cycle. They cover the setup-to-access step, enable and select held through stalls, the address and direction frozen across waits, the done pulse tied to a completion, and the watchdog flag appearing only inside an access phase. The bench scenarios are needed for the rest. They show that the captured data and error bits are the completion-cycle values and not the garbage a subordinate drives while waiting, that the number of access cycles matches the injected wait count, that a request during a stall is dropped, that back-to-back chaining skips idle, and that the watchdog flag starts exactly at its limit.

// File: rtl/apb_rd_pkg.sv
package apb_rd_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACCESS = 2'd2
   } rd_phase_e;
endpackage

// File: rtl/apb_rd_seq.sv
module apb_rd_seq
   import apb_rd_pkg::*;
#(
   parameter int ADDR_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic              pready_i,
   output logic              psel_o,
   output logic              penable_o,
   output logic              pwrite_o,
   output logic [ADDR_W-1:0] paddr_o,
   output logic              complete_o,
   output logic              busy_o
);
   rd_phase_e         phase_q, phase_d;
   logic [ADDR_W-1:0] addr_q;
   logic              take_req;

   assign complete_o = (phase_q == PH_ACCESS) && pready_i;
   assign take_req   = req_i && ((phase_q == PH_IDLE) || complete_o);

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:   if (req_i) phase_d = PH_SETUP;
         PH_SETUP:  phase_d = PH_ACCESS;
         PH_ACCESS: if (pready_i) phase_d = req_i ? PH_SETUP : PH_IDLE;
         default:   phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         addr_q  <= '0;
      end else begin
         phase_q <= phase_d;
         if (take_req) addr_q <= req_addr_i;
      end
   end

   assign psel_o    = (phase_q != PH_IDLE);
   assign penable_o = (phase_q == PH_ACCESS);
   assign pwrite_o  = 1'b0;
   assign paddr_o   = addr_q;
   assign busy_o    = psel_o;

   // R1: setup lasts one cycle and is followed by access
   assert_setup_then_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (psel_o && !penable_o) |=> (psel_o && penable_o));

   // R1: direction is always read
   always_comb assert_read_only_R1: assert (!pwrite_o || !rst_n);

   // R2: a stall keeps select and enable high
   assert_stall_keeps_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (penable_o && !pready_i) |=> (psel_o && penable_o));

   // R3: address and direction frozen across a wait
   assert_hold_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (penable_o && !pready_i) |=> ($stable(paddr_o) && $stable(pwrite_o)));

   // R7: completion with no request goes idle
   assert_idle_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (penable_o && pready_i && !req_i) |=> !psel_o);
endmodule

// File: rtl/apb_rd_capture.sv
module apb_rd_capture #(
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              complete_i,
   input  logic [DATA_W-1:0] prdata_i,
   input  logic              pslverr_i,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              err_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o  <= 1'b0;
         rdata_o <= '0;
         err_o   <= 1'b0;
      end else begin
         done_o <= complete_i;
         if (complete_i) begin
            rdata_o <= prdata_i;
            err_o   <= pslverr_i;
         end
      end
   end

   // R5: every completion yields a done pulse next cycle
   assert_done_after_complete_R5: assert property (@(posedge clk) disable iff (!rst_n)
      complete_i |=> done_o);

   // R5: result holds when no completion occurred
   assert_result_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !complete_i |=> ($stable(rdata_o) && $stable(err_o) && !done_o));
endmodule

// File: rtl/apb_rd_wdog.sv
module apb_rd_wdog #(
   parameter int WDOG_LIMIT = 8
)(
   input  logic clk,
   input  logic rst_n,
   input  logic penable_i,
   input  logic pready_i,
   output logic wdog_o
);
   localparam int CNT_W = $clog2(WDOG_LIMIT + 1);

   logic [CNT_W-1:0] wait_cnt_q;
   logic             wait_cyc;

   assign wait_cyc = penable_i && !pready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_cnt_q <= '0;
         wdog_o     <= 1'b0;
      end else if (!wait_cyc) begin
         wait_cnt_q <= '0;
         wdog_o     <= 1'b0;
      end else begin
         if (wait_cnt_q != CNT_W'(WDOG_LIMIT)) wait_cnt_q <= wait_cnt_q + 1'b1;
         if (wait_cnt_q == CNT_W'(WDOG_LIMIT - 1)) wdog_o <= 1'b1;
      end
   end

   // R9: the flag lives only inside an access phase
   assert_wdog_in_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_o |-> penable_i);

   // R9: once raised, the flag stays while the stall continues
   assert_wdog_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wdog_o && !pready_i) |=> wdog_o);
endmodule

// File: rtl/apb_rd_mgr.sv
module apb_rd_mgr #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter bit WDOG_EN    = 1'b1,
   parameter int WDOG_LIMIT = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              err_o,
   output logic              wdog_o,
   output logic              psel_o,
   output logic              penable_o,
   output logic              pwrite_o,
   output logic [ADDR_W-1:0] paddr_o,
   input  logic [DATA_W-1:0] prdata_i,
   input  logic              pready_i,
   input  logic              pslverr_i
);
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("apb_rd_mgr: ADDR_W must be 1..32");
   end
   if (DATA_W < 8 || DATA_W > 32) begin : g_bad_data_w
      $error("apb_rd_mgr: DATA_W must be 8..32");
   end
   if (WDOG_EN && WDOG_LIMIT < 1) begin : g_bad_limit
      $error("apb_rd_mgr: WDOG_LIMIT must be at least 1");
   end

   logic complete;

   apb_rd_seq #(.ADDR_W(ADDR_W)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .req_addr_i (req_addr_i),
      .pready_i   (pready_i),
      .psel_o     (psel_o),
      .penable_o  (penable_o),
      .pwrite_o   (pwrite_o),
      .paddr_o    (paddr_o),
      .complete_o (complete),
      .busy_o     (busy_o)
   );

   apb_rd_capture #(.DATA_W(DATA_W)) i_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .complete_i (complete),
      .prdata_i   (prdata_i),
      .pslverr_i  (pslverr_i),
      .done_o     (done_o),
      .rdata_o    (rdata_o),
      .err_o      (err_o)
   );

   if (WDOG_EN) begin : g_wdog
      apb_rd_wdog #(.WDOG_LIMIT(WDOG_LIMIT)) i_wdog (
         .clk       (clk),
         .rst_n     (rst_n),
         .penable_i (penable_o),
         .pready_i  (pready_i),
         .wdog_o    (wdog_o)
      );
   end else begin : g_no_wdog
      assign wdog_o = 1'b0;
   end

   // R10: nothing is selected while held in reset
   always_comb assert_reset_quiet_R10: assert (rst_n || (!psel_o && !done_o && !wdog_o));
endmodule

// File: tb/test_apb_rd_mgr.sv
module test_apb_rd_mgr;
   localparam int AW    = 16;
   localparam int DW    = 32;
   localparam int LIMIT = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          busy, done, err, wdog, psel, penable, pwrite;
   logic [DW-1:0] rdata, prdata;
   logic [AW-1:0] paddr;
   logic          pready, pslverr;

   int cfg_wait = 0;
   logic cfg_err = 1'b0;
   int sub_cnt;
   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   apb_rd_mgr #(.ADDR_W(AW), .DATA_W(DW), .WDOG_EN(1'b1), .WDOG_LIMIT(LIMIT)) i_apb_rd_mgr (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_addr_i(req_addr),
      .busy_o(busy), .done_o(done), .rdata_o(rdata), .err_o(err), .wdog_o(wdog),
      .psel_o(psel), .penable_o(penable), .pwrite_o(pwrite), .paddr_o(paddr),
      .prdata_i(prdata), .pready_i(pready), .pslverr_i(pslverr)
   );

   // behavioural subordinate: drives junk and an error on every wait cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sub_cnt <= 0;
      else if (psel && penable && !pready) sub_cnt <= sub_cnt + 1;
      else sub_cnt <= 0;
   end
   assign pready  = psel && penable && (sub_cnt == cfg_wait);
   assign prdata  = pready ? {paddr, ~paddr} : {16'hBAD0, sub_cnt[15:0]};
   assign pslverr = pready ? cfg_err : (psel && penable);

   function automatic void check(input bit ok, input string tag,
                                 input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endfunction

   // follow a transfer from its first access cycle through the result cycle
   task automatic finish_xfer(input logic [AW-1:0] a, input int nw, input logic e,
                              input bit poke, input bit chain, input logic [AW-1:0] nxt);
      int acc = 0;
      int wd = 0;
      int wd_exp = (nw >= LIMIT) ? nw - LIMIT + 1 : 0;
      forever begin
         @(negedge clk);
         req = 1'b0;
         if (!penable || acc > 5000) break;
         acc++;
         if (wdog) wd++;
         check(psel, "R2 psel held in access", 32'(psel), 1);
         check(paddr == a, "R3 paddr frozen", 32'(paddr), 32'(a));
         check(!pwrite, "R3 pwrite frozen low", 32'(pwrite), 0);
         if (poke && acc == 1 && !pready) begin
            req = 1'b1; req_addr = ~a;
         end
         if (chain && pready) begin
            req = 1'b1; req_addr = nxt;
         end
      end
      check(acc == nw + 1, "R4 access cycle count", 32'(acc), 32'(nw + 1));
      check(done, "R5 done pulse", 32'(done), 1);
      check(rdata == {a, ~a}, "R5 completion data", rdata, {a, ~a});
      check(err == e, "R6 completion error", 32'(err), 32'(e));
      check(wd == wd_exp, "R9 watchdog cycles", 32'(wd), 32'(wd_exp));
      if (chain) begin
         check(psel && !penable && paddr == nxt, "R7 direct setup", 32'(paddr), 32'(nxt));
      end else begin
         check(!psel, "R7 idle after completion", 32'(psel), 0);
         @(negedge clk);
         check(!done, "R5 done one cycle", 32'(done), 0);
         check(rdata == {a, ~a}, "R5 data held", rdata, {a, ~a});
         check(!psel, "R8 no extra transfer", 32'(psel), 0);
      end
   endtask

   task automatic start_xfer(input logic [AW-1:0] a, input int nw, input logic e);
      cfg_wait = nw; cfg_err = e;
      @(negedge clk);
      req = 1'b1; req_addr = a;
      @(negedge clk);
      req = 1'b0;
      check(psel && !penable, "R1 setup phase", {30'd0, psel, penable}, 32'h2);
      check(paddr == a, "R1 setup address", 32'(paddr), 32'(a));
      check(!pwrite, "R1 pwrite low", 32'(pwrite), 0);
   endtask

   task automatic t_reset();
      check(!psel && !penable && !done && !wdog && !busy, "R10 reset state",
            {27'd0, psel, penable, done, wdog, busy}, 0);
   endtask

   task automatic t_read(input logic [AW-1:0] a, input int nw, input logic e);
      start_xfer(a, nw, e);
      finish_xfer(a, nw, e, 1'b0, 1'b0, '0);
   endtask

   task automatic t_ignored_req();
      start_xfer(16'h3C5A, 4, 1'b0);
      finish_xfer(16'h3C5A, 4, 1'b0, 1'b1, 1'b0, '0);
   endtask

   task automatic t_chain();
      start_xfer(16'h1111, 3, 1'b0);
      finish_xfer(16'h1111, 3, 1'b0, 1'b0, 1'b1, 16'h2222);
      req = 1'b0; cfg_wait = 0; cfg_err = 1'b1;
      finish_xfer(16'h2222, 0, 1'b1, 1'b0, 1'b0, '0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read(16'h0004, 0, 1'b0);
      t_read(16'h0A10, 1, 1'b0);
      t_read(16'hBEEF, 3, 1'b1);
      t_read(16'h0100, LIMIT - 1, 1'b0);
      t_read(16'h0200, LIMIT, 1'b0);
      t_read(16'h0300, 12, 1'b0);
      t_read(16'h0400, 40, 1'b0);
      t_ignored_req();
      t_chain();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule